// File: doc/BRIEF.md
# Interleaved Dual-Bank Data Memory

This block is a word-addressed data memory that serves several requesters in the same clock cycle. Storage is split in two halves: every even address lives in one bank and every odd address in the other. Each bank has one port for each requester. Because of this split, a single request can reach an even location and the odd location just after it in one cycle.

The core address generator drives a set of lanes. Each lane carries one request per cycle. A request is either a scalar access to a single word or a vector access to an aligned even/odd pair. A lane uses at most one port on each bank, so two lanes give the core up to four word accesses per cycle. Two more single-word ports serve a DMA engine and an external slave-side master. With the default two lanes, up to six words move per cycle.

Every port answers one cycle after its request with a valid pulse and registered read data. When several writes reach the same word in one cycle, a fixed priority decides which one is stored. Word width and address width are parameters; a 14-bit address gives the full 16K-word configuration.

Top module: `dbmem_top`

## Requirements
- R1: Address bit 0 selects the bank (0 = even bank, 1 = odd bank), and the upper address bits select the word inside that bank. A scalar word written through any port reads back unchanged through any other port.
- R2: An aligned vector access (vector flag set, address bit 0 clear) reads or writes address A and address A+1 in one cycle. The low data half belongs to A and the high half to A+1.
- R3: A vector request with an odd address is misaligned. It returns the error flag together with its valid pulse one cycle later, returns all-zero data, and changes no memory word.
- R4: Every lane, DMA and slave request gets exactly one valid pulse, one cycle after the request. No valid pulse appears without a request.
- R5: All ports are served in the same cycle with no stall: two lane vector reads plus a DMA read and a slave read return six distinct words together.
- R6: When several writes target one word in the same cycle, the stored value comes from the highest-priority writer. The order, from highest to lowest, is lane 0, then higher lane numbers, then DMA, then slave.
- R7: A read and a write to the same word in the same cycle return the value held before that cycle. The written value is seen from the next cycle on.
- R8: DMA and slave responses carry the addressed word for a read and all-zero data for a write.
- R9: While reset is asserted and in the first cycle after it, every valid and error output is low.
- R10: A lane's scalar read returns the word on the low data half and zero on the high half. A lane write returns zero on both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_req_i | input | NL | Per-lane request |
| lane_we_i | input | NL | Per-lane write enable |
| lane_vec_i | input | NL | Per-lane vector (pair) access |
| lane_addr_i | input | NL x AW | Per-lane word address |
| lane_wlo_i | input | NL x W | Write data for the addressed word |
| lane_whi_i | input | NL x W | Write data for the next word (vector only) |
| lane_vld_o | output | NL | Per-lane response valid |
| lane_err_o | output | NL | Misaligned vector flag |
| lane_rlo_o | output | NL x W | Read data, addressed word |
| lane_rhi_o | output | NL x W | Read data, next word (vector only) |
| dma_req_i | input | 1 | DMA request |
| dma_we_i | input | 1 | DMA write enable |
| dma_addr_i | input | AW | DMA word address |
| dma_wdata_i | input | W | DMA write data |
| dma_vld_o | output | 1 | DMA response valid |
| dma_rdata_o | output | W | DMA read data |
| slv_req_i | input | 1 | Slave-side request |
| slv_we_i | input | 1 | Slave-side write enable |
| slv_addr_i | input | AW | Slave-side word address |
| slv_wdata_i | input | W | Slave-side write data |
| slv_vld_o | output | 1 | Slave-side response valid |
| slv_rdata_o | output | W | Slave-side read data |

## Verification
The assertions assume that request, write-enable, vector and address inputs hold known values on every clock edge after reset. They also assume the requesters are held idle while reset is asserted. The bench drives every input from a single task at the falling edge and keeps all requests low during reset. Random addresses are drawn from a narrow window most of the time, so same-word collisions and same-cycle read/write pairs occur often. The rest of the time they are drawn from the full address range. Before any random reads, the bench fills the whole memory with known values, so no read returns an unwritten word.

// File: rtl/dbmem_pkg.sv
package dbmem_pkg;

    // Classification of one port's request for the current cycle.
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_SCALAR = 2'd1,
        OP_VECTOR = 2'd2,
        OP_BAD    = 2'd3
    } op_kind_e;

    // What a port needs to remember to shape its response one cycle later.
    typedef struct packed {
        logic vld;
        logic vec;
        logic odd;
        logic err;
    } resp_tag_t;

    localparam int unsigned NBANK = 2;

endpackage

// File: rtl/dbmem_route.sv
module dbmem_route
    import dbmem_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned W  = 40
) (
    input  logic                 req_i,
    input  logic                 we_i,
    input  logic                 vec_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [W-1:0]         wlo_i,
    input  logic [W-1:0]         whi_i,
    output logic [1:0]           en_o,
    output logic [1:0]           we_o,
    output logic [AW-2:0]        idx_o,
    output logic [1:0][W-1:0]    wd_o,
    output op_kind_e             kind_o
);

    always_comb begin
        en_o   = 2'b00;
        wd_o   = '0;
        idx_o  = addr_i[AW-1:1];
        kind_o = OP_IDLE;
        if (req_i) begin
            if (vec_i && addr_i[0]) begin
                kind_o = OP_BAD;
            end else if (vec_i) begin
                kind_o  = OP_VECTOR;
                en_o    = 2'b11;
                wd_o[0] = wlo_i;
                wd_o[1] = whi_i;
            end else begin
                kind_o            = OP_SCALAR;
                en_o[addr_i[0]]   = 1'b1;
                wd_o[addr_i[0]]   = wlo_i;
            end
        end
        we_o = en_o & {2{we_i}};
    end

endmodule

// File: rtl/dbmem_bank.sv
module dbmem_bank #(
    parameter int unsigned W     = 40,
    parameter int unsigned IW    = 9,
    parameter int unsigned NPORT = 4
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NPORT-1:0]            en_i,
    input  logic [NPORT-1:0]            we_i,
    input  logic [NPORT-1:0][IW-1:0]    idx_i,
    input  logic [NPORT-1:0][W-1:0]     wd_i,
    output logic [NPORT-1:0][W-1:0]     rd_o
);

    localparam int unsigned DEPTH = 2 ** IW;

    logic [W-1:0]            mem [DEPTH];
    logic [NPORT-1:0][W-1:0] rd_d, rd_q;

    // Reads see the array contents from before this cycle's writes.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            rd_d[p] = (en_i[p] && !we_i[p]) ? mem[idx_i[p]] : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    // Lowest port index has the highest priority: it is assigned last.
    always_ff @(posedge clk_i) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (en_i[p] && we_i[p]) begin
                mem[idx_i[p]] <= wd_i[p];
            end
        end
    end

    assign rd_o = rd_q;

endmodule

// File: rtl/dbmem_top.sv
module dbmem_top
    import dbmem_pkg::*;
#(
    parameter int unsigned NL = 2,
    parameter int unsigned AW = 10,
    parameter int unsigned W  = 40
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NL-1:0]          lane_req_i,
    input  logic [NL-1:0]          lane_we_i,
    input  logic [NL-1:0]          lane_vec_i,
    input  logic [NL-1:0][AW-1:0]  lane_addr_i,
    input  logic [NL-1:0][W-1:0]   lane_wlo_i,
    input  logic [NL-1:0][W-1:0]   lane_whi_i,
    output logic [NL-1:0]          lane_vld_o,
    output logic [NL-1:0]          lane_err_o,
    output logic [NL-1:0][W-1:0]   lane_rlo_o,
    output logic [NL-1:0][W-1:0]   lane_rhi_o,
    input  logic                   dma_req_i,
    input  logic                   dma_we_i,
    input  logic [AW-1:0]          dma_addr_i,
    input  logic [W-1:0]           dma_wdata_i,
    output logic                   dma_vld_o,
    output logic [W-1:0]           dma_rdata_o,
    input  logic                   slv_req_i,
    input  logic                   slv_we_i,
    input  logic [AW-1:0]          slv_addr_i,
    input  logic [W-1:0]           slv_wdata_i,
    output logic                   slv_vld_o,
    output logic [W-1:0]           slv_rdata_o
);

    localparam int unsigned NPORT = NL + 2;
    localparam int unsigned IW    = AW - 1;
    localparam int unsigned P_DMA = NL;
    localparam int unsigned P_SLV = NL + 1;

    // Flattened per-port view, in priority order.
    logic [NPORT-1:0]          p_req, p_we, p_vec;
    logic [NPORT-1:0][AW-1:0]  p_addr;
    logic [NPORT-1:0][W-1:0]   p_wlo, p_whi;

    always_comb begin
        for (int l = 0; l < NL; l++) begin
            p_req[l]  = lane_req_i[l];
            p_we[l]   = lane_we_i[l];
            p_vec[l]  = lane_vec_i[l];
            p_addr[l] = lane_addr_i[l];
            p_wlo[l]  = lane_wlo_i[l];
            p_whi[l]  = lane_whi_i[l];
        end
        p_req[P_DMA]  = dma_req_i;
        p_we[P_DMA]   = dma_we_i;
        p_vec[P_DMA]  = 1'b0;
        p_addr[P_DMA] = dma_addr_i;
        p_wlo[P_DMA]  = dma_wdata_i;
        p_whi[P_DMA]  = '0;
        p_req[P_SLV]  = slv_req_i;
        p_we[P_SLV]   = slv_we_i;
        p_vec[P_SLV]  = 1'b0;
        p_addr[P_SLV] = slv_addr_i;
        p_wlo[P_SLV]  = slv_wdata_i;
        p_whi[P_SLV]  = '0;
    end

    // Per-port routing to the two banks.
    logic [1:0]          r_en   [NPORT];
    logic [1:0]          r_we   [NPORT];
    logic [IW-1:0]       r_idx  [NPORT];
    logic [1:0][W-1:0]   r_wd   [NPORT];
    op_kind_e            r_kind [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_route
        dbmem_route #(.AW(AW), .W(W)) u_route (
            .req_i  (p_req[p]),
            .we_i   (p_we[p]),
            .vec_i  (p_vec[p]),
            .addr_i (p_addr[p]),
            .wlo_i  (p_wlo[p]),
            .whi_i  (p_whi[p]),
            .en_o   (r_en[p]),
            .we_o   (r_we[p]),
            .idx_o  (r_idx[p]),
            .wd_o   (r_wd[p]),
            .kind_o (r_kind[p])
        );
    end

    // Crossbar: transpose port-major routing into bank-major port lists.
    logic [NPORT-1:0]          bk_en  [NBANK];
    logic [NPORT-1:0]          bk_we  [NBANK];
    logic [NPORT-1:0][IW-1:0]  bk_idx [NBANK];
    logic [NPORT-1:0][W-1:0]   bk_wd  [NBANK];
    logic [NPORT-1:0][W-1:0]   bk_rd  [NBANK];

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            for (int p = 0; p < NPORT; p++) begin
                bk_en[b][p]  = r_en[p][b];
                bk_we[b][p]  = r_we[p][b];
                bk_idx[b][p] = r_idx[p];
                bk_wd[b][p]  = r_wd[p][b];
            end
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        dbmem_bank #(.W(W), .IW(IW), .NPORT(NPORT)) u_bank (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (bk_en[b]),
            .we_i   (bk_we[b]),
            .idx_i  (bk_idx[b]),
            .wd_i   (bk_wd[b]),
            .rd_o   (bk_rd[b])
        );
    end

    // Response tags: next-value process and register process.
    resp_tag_t tag_d [NPORT];
    resp_tag_t tag_q [NPORT];

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            tag_d[p].vld = p_req[p];
            tag_d[p].vec = (r_kind[p] == OP_VECTOR);
            tag_d[p].odd = p_addr[p][0];
            tag_d[p].err = (r_kind[p] == OP_BAD);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int p = 0; p < NPORT; p++) begin
                tag_q[p] <= '0;
            end
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                tag_q[p] <= tag_d[p];
            end
        end
    end

    // Response shaping from registered bank data and tags.
    logic [NPORT-1:0][W-1:0] o_lo, o_hi;

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            if (tag_q[p].vec) begin
                o_lo[p] = bk_rd[0][p];
                o_hi[p] = bk_rd[1][p];
            end else begin
                o_lo[p] = tag_q[p].odd ? bk_rd[1][p] : bk_rd[0][p];
                o_hi[p] = '0;
            end
        end
    end

    always_comb begin
        for (int l = 0; l < NL; l++) begin
            lane_vld_o[l] = tag_q[l].vld;
            lane_err_o[l] = tag_q[l].err;
            lane_rlo_o[l] = o_lo[l];
            lane_rhi_o[l] = o_hi[l];
        end
    end

    assign dma_vld_o   = tag_q[P_DMA].vld;
    assign dma_rdata_o = o_lo[P_DMA];
    assign slv_vld_o   = tag_q[P_SLV].vld;
    assign slv_rdata_o = o_lo[P_SLV];

endmodule

// File: rtl/dbmem_chk.sv
module dbmem_chk #(
    parameter int unsigned NL = 2,
    parameter int unsigned AW = 10,
    parameter int unsigned W  = 40
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [NL-1:0]          lane_req_i,
    input logic [NL-1:0]          lane_we_i,
    input logic [NL-1:0]          lane_vec_i,
    input logic [NL-1:0][AW-1:0]  lane_addr_i,
    input logic [NL-1:0]          lane_vld_o,
    input logic [NL-1:0]          lane_err_o,
    input logic [NL-1:0][W-1:0]   lane_rlo_o,
    input logic [NL-1:0][W-1:0]   lane_rhi_o,
    input logic                   dma_req_i,
    input logic                   dma_we_i,
    input logic                   dma_vld_o,
    input logic [W-1:0]           dma_rdata_o,
    input logic                   slv_req_i,
    input logic                   slv_we_i,
    input logic                   slv_vld_o,
    input logic [W-1:0]           slv_rdata_o
);

    for (genvar l = 0; l < NL; l++) begin : g_lane
        // R4
        lane_rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lane_req_i[l] |=> lane_vld_o[l]);
        // R4
        lane_no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !lane_req_i[l] |=> !lane_vld_o[l]);
        // R3
        lane_misalign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lane_req_i[l] && lane_vec_i[l] && lane_addr_i[l][0]) |=> lane_err_o[l]);
        // R3
        lane_err_needs_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lane_err_o[l] |-> lane_vld_o[l]);
        // R3
        lane_err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lane_err_o[l] |-> (lane_rlo_o[l] == '0 && lane_rhi_o[l] == '0));
        // R10
        lane_scalar_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lane_req_i[l] && !lane_vec_i[l]) |=> (lane_rhi_o[l] == '0));
    end

    // R4
    dma_rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (dma_vld_o == $past(dma_req_i)));
    // R4
    slv_rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (slv_vld_o == $past(slv_req_i)));
    // R8
    dma_write_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_req_i && dma_we_i) |=> (dma_rdata_o == '0));
    // R8
    slv_write_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slv_req_i && slv_we_i) |=> (slv_rdata_o == '0));

endmodule

bind dbmem_top dbmem_chk #(.NL(NL), .AW(AW), .W(W)) u_dbmem_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lane_req_i  (lane_req_i),
    .lane_we_i   (lane_we_i),
    .lane_vec_i  (lane_vec_i),
    .lane_addr_i (lane_addr_i),
    .lane_vld_o  (lane_vld_o),
    .lane_err_o  (lane_err_o),
    .lane_rlo_o  (lane_rlo_o),
    .lane_rhi_o  (lane_rhi_o),
    .dma_req_i   (dma_req_i),
    .dma_we_i    (dma_we_i),
    .dma_vld_o   (dma_vld_o),
    .dma_rdata_o (dma_rdata_o),
    .slv_req_i   (slv_req_i),
    .slv_we_i    (slv_we_i),
    .slv_vld_o   (slv_vld_o),
    .slv_rdata_o (slv_rdata_o)
);

// File: tb/dbmem_top_test.sv
module dbmem_top_test;

    localparam int unsigned NL    = 2;
    localparam int unsigned AW    = 10;
    localparam int unsigned W     = 40;
    localparam int unsigned DEPTH = 2 ** AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NL-1:0]          lane_req, lane_we, lane_vec;
    logic [NL-1:0][AW-1:0]  lane_addr;
    logic [NL-1:0][W-1:0]   lane_wlo, lane_whi;
    logic [NL-1:0]          lane_vld, lane_err;
    logic [NL-1:0][W-1:0]   lane_rlo, lane_rhi;
    logic                   dma_req, dma_we, dma_vld, slv_req, slv_we, slv_vld;
    logic [AW-1:0]          dma_addr, slv_addr;
    logic [W-1:0]           dma_wdata, slv_wdata, dma_rdata, slv_rdata;

    dbmem_top #(.NL(NL), .AW(AW), .W(W)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .lane_req_i(lane_req), .lane_we_i(lane_we), .lane_vec_i(lane_vec),
        .lane_addr_i(lane_addr), .lane_wlo_i(lane_wlo), .lane_whi_i(lane_whi),
        .lane_vld_o(lane_vld), .lane_err_o(lane_err),
        .lane_rlo_o(lane_rlo), .lane_rhi_o(lane_rhi),
        .dma_req_i(dma_req), .dma_we_i(dma_we), .dma_addr_i(dma_addr),
        .dma_wdata_i(dma_wdata), .dma_vld_o(dma_vld), .dma_rdata_o(dma_rdata),
        .slv_req_i(slv_req), .slv_we_i(slv_we), .slv_addr_i(slv_addr),
        .slv_wdata_i(slv_wdata), .slv_vld_o(slv_vld), .slv_rdata_o(slv_rdata)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string ph = "";

    logic [W-1:0] model [DEPTH];

    // Expected responses for the operation currently in flight.
    bit                     have_exp = 1'b0;
    logic [NL-1:0]          e_vld, e_err;
    logic [NL-1:0][W-1:0]   e_lo, e_hi;
    logic                   e_dvld, e_svld;
    logic [W-1:0]           e_drd, e_srd;
    logic [NL-1:0]          e_vec;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, ph, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd_word();
        return {$urandom, $urandom} & {W{1'b1}};
    endfunction

    task automatic idle_inputs();
        lane_req = '0; lane_we = '0; lane_vec = '0; lane_addr = '0;
        lane_wlo = '0; lane_whi = '0;
        dma_req = 1'b0; dma_we = 1'b0; dma_addr = '0; dma_wdata = '0;
        slv_req = 1'b0; slv_we = 1'b0; slv_addr = '0; slv_wdata = '0;
    endtask

    task automatic compare_prev();
        if (!have_exp) return;
        for (int l = 0; l < NL; l++) begin
            chk("R4", W'(lane_vld[l]), W'(e_vld[l]));
            chk("R3", W'(lane_err[l]), W'(e_err[l]));
            chk(e_vec[l] ? "R2" : "R1", lane_rlo[l], e_lo[l]);
            chk(e_vec[l] ? "R2" : "R10", lane_rhi[l], e_hi[l]);
        end
        chk("R4", W'(dma_vld), W'(e_dvld));
        chk("R8", dma_rdata, e_drd);
        chk("R4", W'(slv_vld), W'(e_svld));
        chk("R8", slv_rdata, e_srd);
    endtask

    // Expected values from the pre-cycle model, then writes in rising priority.
    task automatic predict();
        for (int l = 0; l < NL; l++) begin
            logic bad;
            bad      = lane_req[l] && lane_vec[l] && lane_addr[l][0];
            e_vld[l] = lane_req[l];
            e_err[l] = bad;
            e_vec[l] = lane_req[l] && lane_vec[l] && !bad;
            e_lo[l]  = '0;
            e_hi[l]  = '0;
            if (lane_req[l] && !lane_we[l] && !bad) begin
                e_lo[l] = model[lane_addr[l]];
                if (lane_vec[l]) e_hi[l] = model[lane_addr[l] + 1];
            end
        end
        e_dvld = dma_req;
        e_drd  = (dma_req && !dma_we) ? model[dma_addr] : '0;
        e_svld = slv_req;
        e_srd  = (slv_req && !slv_we) ? model[slv_addr] : '0;
        if (slv_req && slv_we) model[slv_addr] = slv_wdata;
        if (dma_req && dma_we) model[dma_addr] = dma_wdata;
        for (int l = NL - 1; l >= 0; l--) begin
            if (lane_req[l] && lane_we[l] && !(lane_vec[l] && lane_addr[l][0])) begin
                model[lane_addr[l]] = lane_wlo[l];
                if (lane_vec[l]) model[lane_addr[l] + 1] = lane_whi[l];
            end
        end
        have_exp = 1'b1;
    endtask

    // Caller has staged inputs in n_* shadow copies via the stage_* tasks.
    logic [NL-1:0]          n_req, n_we, n_vec;
    logic [NL-1:0][AW-1:0]  n_addr;
    logic [NL-1:0][W-1:0]   n_wlo, n_whi;
    logic                   n_dreq, n_dwe, n_sreq, n_swe;
    logic [AW-1:0]          n_daddr, n_saddr;
    logic [W-1:0]           n_dwd, n_swd;

    task automatic clear_stage();
        n_req = '0; n_we = '0; n_vec = '0; n_addr = '0; n_wlo = '0; n_whi = '0;
        n_dreq = 0; n_dwe = 0; n_sreq = 0; n_swe = 0;
        n_daddr = '0; n_saddr = '0; n_dwd = '0; n_swd = '0;
    endtask

    task automatic run();
        @(negedge clk);
        compare_prev();
        lane_req = n_req; lane_we = n_we; lane_vec = n_vec; lane_addr = n_addr;
        lane_wlo = n_wlo; lane_whi = n_whi;
        dma_req = n_dreq; dma_we = n_dwe; dma_addr = n_daddr; dma_wdata = n_dwd;
        slv_req = n_sreq; slv_we = n_swe; slv_addr = n_saddr; slv_wdata = n_swd;
        predict();
        clear_stage();
    endtask

    task automatic lane_op(input int l, input bit we, input bit vec,
                           input int addr, input logic [W-1:0] lo, input logic [W-1:0] hi);
        n_req[l] = 1'b1; n_we[l] = we; n_vec[l] = vec;
        n_addr[l] = AW'(addr); n_wlo[l] = lo; n_whi[l] = hi;
    endtask

    task automatic finish_run();
        if (finished) return;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        clear_stage();
        // R9: reset state
        ph = "R9";
        repeat (3) @(negedge clk);
        chk("R9", W'({lane_vld, lane_err, dma_vld, slv_vld}), '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", W'({lane_vld, lane_err, dma_vld, slv_vld}), '0);

        // Fill the whole memory with vector writes (R2).
        ph = "R2 fill";
        for (int a = 0; a < DEPTH; a += 4) begin
            lane_op(0, 1, 1, a, rnd_word(), rnd_word());
            lane_op(1, 1, 1, a + 2, rnd_word(), rnd_word());
            run();
        end

        // R1: scalar writes on each bank, read back on other ports.
        ph = "R1";
        lane_op(0, 1, 0, 5, 40'h11_2233_4455, '0);
        n_sreq = 1; n_swe = 1; n_saddr = 4; n_swd = 40'hAA_BBCC_DDEE;
        run();
        n_dreq = 1; n_daddr = 5;
        lane_op(1, 0, 0, 4, '0, '0);
        run();
        run();

        // R3: misaligned vector write leaves words unchanged.
        ph = "R3";
        lane_op(0, 1, 1, 7, 40'hDE_AD00_0001, 40'hDE_AD00_0002);
        lane_op(1, 0, 1, 9, '0, '0);
        run();
        lane_op(0, 0, 0, 7, '0, '0);
        lane_op(1, 0, 0, 8, '0, '0);
        run();
        run();

        // R6: write collisions on one word.
        ph = "R6 all";
        lane_op(0, 1, 0, 10, 40'h00_0000_0A00, '0);
        lane_op(1, 1, 0, 10, 40'h00_0000_0A01, '0);
        n_dreq = 1; n_dwe = 1; n_daddr = 10; n_dwd = 40'h00_0000_0A02;
        n_sreq = 1; n_swe = 1; n_saddr = 10; n_swd = 40'h00_0000_0A03;
        run();
        n_dreq = 1; n_daddr = 10;
        run();
        ph = "R6 dma-slv";
        n_dreq = 1; n_dwe = 1; n_daddr = 11; n_dwd = 40'h00_0000_0B02;
        n_sreq = 1; n_swe = 1; n_saddr = 11; n_swd = 40'h00_0000_0B03;
        run();
        n_sreq = 1; n_saddr = 11;
        run();
        run();

        // R7: same-cycle read and write return old data.
        ph = "R7";
        lane_op(0, 1, 1, 12, 40'h77_0000_0012, 40'h77_0000_0013);
        n_dreq = 1; n_daddr = 12;
        lane_op(1, 0, 1, 12, '0, '0);
        run();
        n_sreq = 1; n_saddr = 13;
        run();
        run();

        // R5: six distinct words in one cycle.
        ph = "R5";
        lane_op(0, 0, 1, 100, '0, '0);
        lane_op(1, 0, 1, 202, '0, '0);
        n_dreq = 1; n_daddr = 301;
        n_sreq = 1; n_saddr = 402;
        run();
        run();

        // Random traffic, narrow window for collisions.
        ph = "random";
        for (int i = 0; i < 3000; i++) begin
            int span;
            span = ($urandom_range(0, 3) == 0) ? DEPTH : 16;
            for (int l = 0; l < NL; l++) begin
                if ($urandom_range(0, 3) != 0) begin
                    int a;
                    bit v;
                    v = $urandom_range(0, 1);
                    a = $urandom_range(0, span - 2);
                    if (v && $urandom_range(0, 7) != 0) a = a & ~1;
                    lane_op(l, $urandom_range(0, 1), v, a, rnd_word(), rnd_word());
                end
            end
            if ($urandom_range(0, 2) != 0) begin
                n_dreq = 1; n_dwe = $urandom_range(0, 1);
                n_daddr = AW'($urandom_range(0, span - 1)); n_dwd = rnd_word();
            end
            if ($urandom_range(0, 2) != 0) begin
                n_sreq = 1; n_swe = $urandom_range(0, 1);
                n_saddr = AW'($urandom_range(0, span - 1)); n_swd = rnd_word();
            end
            run();
        end
        run();
        finish_run();
    end

endmodule